// File: doc/BRIEF.md
# Banked Window Bus Bridge

This block sits on the 16-bit, byte-wide local bus of an 8-bit sound co-processor and decodes the few addresses that concern it. A small group of four local addresses reaches an FM synthesiser port. One address feeds a serially loaded bank register. Every address in the upper half of the local space is forwarded to a larger 24-bit host bus as a single-byte request.

The host address is built from two parts. The bank register supplies the upper bits, and the low fifteen local address bits supply the rest. Each 32 KB slice of the host space can therefore be reached through the local window. The bank register is not written in parallel. Software loads it one bit per write, with bit 0 of the written data entering at the top of the register. After nine writes, the first bit written has reached the bottom.

Host accesses use a request/acknowledge handshake. The local bus is held with a wait signal until the host acknowledges. FM and bank accesses complete in the cycle they are presented. Reads of any address the block does not own return all ones, and writes to such addresses are dropped.

Top module: `bwb_bridge`

## Requirements
- R1: After reset the bank register holds zero, no host request is pending and the wait output is low.
- R2: Each write to local address 0x6000 shifts bit 0 of the write data into bank bit 8 while every older bit moves one position toward bit 0; after nine such writes the first bit written sits in bit 0.
- R3: A local access with address bit 15 set issues a host request whose 24-bit address is the 9-bit bank value in bits 23:15 and local address bits 14:0 in bits 14:0; address and direction stay stable while the request is pending.
- R4: A read of any of local addresses 0x4000, 0x4001, 0x4002 or 0x4003 returns the FM status input in the same cycle, without wait.
- R5: A write to 0x4000 pulses the FM address strobe for one cycle with part select 0, and a write to 0x4002 pulses it with part select 1; the FM data output carries the written byte.
- R6: A write to 0x4001 or 0x4003 pulses the FM data strobe for one cycle with the written byte and no address strobe.
- R7: A host-window read holds wait high from the first cycle of the access until the cycle after the host acknowledge. In that cycle wait is low and the read data equals the byte presented with the acknowledge.
- R8: A host-window write presents the write byte and write direction on the host bus and completes under the same handshake as a read.
- R9: A read of an unmapped local address, including a read of 0x6000, returns 0xFF. A write to an unmapped address raises no strobe and no host request and leaves the bank register unchanged.
- R10: The bank value persists unchanged across host-window accesses and FM accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local access valid, held while wait is high |
| loc_we | input | 1 | Local access is a write |
| loc_addr | input | 16 | Local byte address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |
| loc_wait | output | 1 | Stall for the current local access |
| fm_addr_stb | output | 1 | FM register-address latch strobe |
| fm_part | output | 1 | FM register part select for the address strobe |
| fm_data_stb | output | 1 | FM data write strobe |
| fm_wdata | output | 8 | Byte carried by either FM strobe |
| fm_status | input | 8 | FM status byte |
| host_req | output | 1 | Host byte request pending |
| host_we | output | 1 | Host request is a write |
| host_addr | output | 24 | Host byte address |
| host_wdata | output | 8 | Host write byte |
| host_ack | input | 1 | Host acknowledge, one cycle |
| host_rdata | input | 8 | Host read byte, valid with acknowledge |

## Verification
The bank register can only be seen through the upper bits of the host address. A lost or misordered shift therefore stays invisible until the next host-window access, where it shows as a wrong address in the first cycle of the request. For that reason the bench follows every group of bank writes, and every write that must not touch the bank, with a host access. Wrong handshake state shows as wait held one cycle too long or too short, or as read data that does not match the byte offered with the acknowledge. Wrong decoding shows in the same cycle as a stray or missing FM strobe, or as a read value other than the status byte or 0xFF.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

    typedef enum logic [1:0] {
        RG_UNMAPPED = 2'd0,
        RG_FM       = 2'd1,
        RG_BANK     = 2'd2,
        RG_HOST     = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        HP_IDLE = 2'd0,
        HP_BUSY = 2'd1,
        HP_DONE = 2'd2
    } hp_state_e;

endpackage

// File: rtl/bwb_decode.sv
module bwb_decode
    import bwb_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          FM_SPAN_W = 2,
    parameter logic [15:0] FM_BASE   = 16'h4000,
    parameter logic [15:0] BANK_ADDR = 16'h6000
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW-1:0] FM_B = FM_BASE[AW-1:0];
    localparam logic [AW-1:0] BK_A = BANK_ADDR[AW-1:0];

    always_comb begin
        if (addr[AW-1])
            region = RG_HOST;
        else if (addr[AW-1:FM_SPAN_W] == FM_B[AW-1:FM_SPAN_W])
            region = RG_FM;
        else if (addr == BK_A)
            region = RG_BANK;
        else
            region = RG_UNMAPPED;
    end

endmodule

// File: rtl/bwb_bank_shifter.sv
module bwb_bank_shifter #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (shift_en)
            bank_d = {bit_in, bank_q[BANK_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;

    // R2: the new bit enters at the top, the rest move down one place
    assert_shift_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> bank_q[BANK_W-1] == $past(bit_in));
    assert_shift_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1]));
    // R10: no write to the bank address, no change
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bank_q));

endmodule

// File: rtl/bwb_host_port.sv
module bwb_host_port
    import bwb_pkg::*;
#(
    parameter int HOST_AW = 24,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic [HOST_AW-1:0] addr,
    input  logic [DW-1:0]      wdata,
    output logic               stall,
    output logic [DW-1:0]      rdata,
    output logic               host_req,
    output logic               host_we,
    output logic [HOST_AW-1:0] host_addr,
    output logic [DW-1:0]      host_wdata,
    input  logic               host_ack,
    input  logic [DW-1:0]      host_rdata
);
    typedef struct packed {
        hp_state_e          state;
        logic               we;
        logic [HOST_AW-1:0] addr;
        logic [DW-1:0]      wdata;
        logic [DW-1:0]      rdata;
    } hp_regs_t;

    hp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            HP_IDLE: begin
                if (start) begin
                    r_d.state = HP_BUSY;
                    r_d.we    = we;
                    r_d.addr  = addr;
                    r_d.wdata = wdata;
                end
            end
            HP_BUSY: begin
                if (host_ack) begin
                    r_d.state = HP_DONE;
                    r_d.rdata = host_rdata;
                end
            end
            HP_DONE: r_d.state = HP_IDLE;
            default: r_d.state = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= HP_IDLE;
            r_q.we    <= 1'b0;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stall      = start_or_busy();
    assign rdata      = r_q.rdata;
    assign host_req   = (r_q.state == HP_BUSY);
    assign host_we    = r_q.we;
    assign host_addr  = r_q.addr;
    assign host_wdata = r_q.wdata;

    function automatic logic start_or_busy();
        return (start && r_q.state == HP_IDLE) || (r_q.state == HP_BUSY);
    endfunction

    // R3: request fields hold until acknowledged
    assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_ack |=> host_req && $stable(host_addr) && $stable(host_we));
    // R7: acknowledge releases the stall in the following cycle
    assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ack |=> !host_req && !stall);
    // R7: read data offered with the acknowledge is what gets returned
    assert_ack_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ack |=> rdata == $past(host_rdata));

endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge
    import bwb_pkg::*;
#(
    parameter int          BANK_W    = 9,
    parameter int          WIN_W     = 15,
    parameter int          DW        = 8,
    parameter logic [15:0] FM_BASE   = 16'h4000,
    parameter logic [15:0] BANK_ADDR = 16'h6000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loc_req,
    input  logic                    loc_we,
    input  logic [WIN_W:0]          loc_addr,
    input  logic [DW-1:0]           loc_wdata,
    output logic [DW-1:0]           loc_rdata,
    output logic                    loc_wait,
    output logic                    fm_addr_stb,
    output logic                    fm_part,
    output logic                    fm_data_stb,
    output logic [DW-1:0]           fm_wdata,
    input  logic [DW-1:0]           fm_status,
    output logic                    host_req,
    output logic                    host_we,
    output logic [BANK_W+WIN_W-1:0] host_addr,
    output logic [DW-1:0]           host_wdata,
    input  logic                    host_ack,
    input  logic [DW-1:0]           host_rdata
);
    localparam int LOC_AW  = WIN_W + 1;
    localparam int HOST_AW = BANK_W + WIN_W;

    region_e           region;
    logic [BANK_W-1:0] bank;
    logic              bank_shift;
    logic              host_start;
    logic              host_stall;
    logic [DW-1:0]     host_rd;
    logic              fm_wr;

    bwb_decode #(
        .AW       (LOC_AW),
        .FM_SPAN_W(2),
        .FM_BASE  (FM_BASE),
        .BANK_ADDR(BANK_ADDR)
    ) u_decode (
        .addr  (loc_addr),
        .region(region)
    );

    assign bank_shift = loc_req && loc_we && (region == RG_BANK);

    bwb_bank_shifter #(.BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(bank_shift),
        .bit_in  (loc_wdata[0]),
        .bank    (bank)
    );

    assign host_start = loc_req && (region == RG_HOST);

    bwb_host_port #(.HOST_AW(HOST_AW), .DW(DW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (host_start),
        .we        (loc_we),
        .addr      ({bank, loc_addr[WIN_W-1:0]}),
        .wdata     (loc_wdata),
        .stall     (host_stall),
        .rdata     (host_rd),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_ack  (host_ack),
        .host_rdata(host_rdata)
    );

    assign fm_wr       = loc_req && loc_we && (region == RG_FM);
    assign fm_addr_stb = fm_wr && !loc_addr[0];
    assign fm_data_stb = fm_wr && loc_addr[0];
    assign fm_part     = loc_addr[1];
    assign fm_wdata    = loc_wdata;

    assign loc_wait = host_start && host_stall;

    always_comb begin
        unique case (region)
            RG_FM:   loc_rdata = fm_status;
            RG_HOST: loc_rdata = host_rd;
            default: loc_rdata = '1;
        endcase
    end

    // R5/R6: at most one kind of side effect at a time
    assert_one_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fm_addr_stb, fm_data_stb, bank_shift}));
    // R9: unmapped reads return all ones
    assert_unmapped_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req && !loc_we && region == RG_UNMAPPED |-> loc_rdata == '1);
    // R4: status reads never stall
    assert_fm_nowait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req && region == RG_FM |-> !loc_wait && loc_rdata == fm_status);
    // R3: a new request carries the window offset of the local address
    assert_req_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_req) |-> host_addr[WIN_W-1:0] == $past(loc_addr[WIN_W-1:0]));

endmodule

// File: tb/bwb_bridge_test.sv
`timescale 1ns/1ps
module bwb_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req = 1'b0, loc_we = 1'b0;
    logic [15:0] loc_addr = '0;
    logic [7:0]  loc_wdata = '0;
    logic [7:0]  loc_rdata;
    logic        loc_wait;
    logic        fm_addr_stb, fm_part, fm_data_stb;
    logic [7:0]  fm_wdata;
    logic [7:0]  fm_status = 8'h5A;
    logic        host_req, host_we;
    logic [23:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_ack = 1'b0;
    logic [7:0]  host_rdata = '0;

    int checks = 0;
    int fails = 0;
    logic [8:0] exp_bank = '0;

    always #4 clk = ~clk;

    bwb_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_wait(loc_wait),
        .fm_addr_stb(fm_addr_stb), .fm_part(fm_part), .fm_data_stb(fm_data_stb),
        .fm_wdata(fm_wdata), .fm_status(fm_status),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    // one-cycle local access without wait; caller checks inside
    task automatic loc_drive(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_req = 1'b1; loc_we = we; loc_addr = a; loc_wdata = d;
        #1;
    endtask

    task automatic loc_end();
        @(negedge clk);
        loc_req = 1'b0; loc_we = 1'b0;
    endtask

    task automatic bank_write(input logic b);
        loc_drive(1'b1, 16'h6000, {7'h55, b});
        check("R2 bank write no wait", loc_wait, 0);
        exp_bank = {b, exp_bank[8:1]};
        loc_end();
    endtask

    // host window access with ack after 'dly' waiting cycles
    task automatic host_xfer(input string rq, input logic we, input logic [15:0] a,
                             input logic [7:0] d, input int dly, input logic [7:0] rd);
        loc_drive(we, a, d);
        check({rq, " wait in first cycle"}, loc_wait, 1);
        @(negedge clk);
        check({rq, " host_req"}, host_req, 1);
        check({rq, " R3 host address"}, host_addr, {exp_bank, a[14:0]});
        check({rq, " host direction"}, host_we, we);
        if (we) check({rq, " R8 host wdata"}, host_wdata, d);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check({rq, " R3 address held"}, host_addr, {exp_bank, a[14:0]});
            check({rq, " R7 still waiting"}, loc_wait, 1);
        end
        host_ack = 1'b1; host_rdata = rd;
        @(negedge clk);
        host_ack = 1'b0; host_rdata = 8'h00;
        #1;
        check({rq, " R7 wait released"}, loc_wait, 0);
        check({rq, " request dropped"}, host_req, 0);
        if (!we) check({rq, " R7 read data"}, loc_rdata, rd);
        loc_end();
    endtask

    task automatic t_reset();
        #1;
        check("R1 wait low in reset", loc_wait, 0);
        check("R1 no host request", host_req, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        host_xfer("R1 bank zero", 1'b0, 16'h8000, 8'h00, 0, 8'h3C);
    endtask

    task automatic t_fm();
        logic [1:0] k;
        for (int i = 0; i < 4; i++) begin
            k = 2'(i);
            fm_status = 8'hA0 + 8'(i);
            loc_drive(1'b0, {14'h1000, k}, 8'h00);
            check("R4 status read", loc_rdata, 8'hA0 + 8'(i));
            check("R4 no wait", loc_wait, 0);
            loc_end();
        end
        loc_drive(1'b1, 16'h4000, 8'h2B);
        check("R5 addr strobe part0", {fm_addr_stb, fm_part, fm_data_stb}, 3'b100);
        check("R5 data byte", fm_wdata, 8'h2B);
        loc_end();
        #1 check("R5 strobe one cycle", fm_addr_stb, 0);
        loc_drive(1'b1, 16'h4002, 8'hB4);
        check("R5 addr strobe part1", {fm_addr_stb, fm_part, fm_data_stb}, 3'b110);
        check("R5 data byte part1", fm_wdata, 8'hB4);
        loc_end();
        loc_drive(1'b1, 16'h4001, 8'h77);
        check("R6 data strobe 4001", {fm_addr_stb, fm_data_stb}, 2'b01);
        check("R6 data byte", fm_wdata, 8'h77);
        loc_end();
        loc_drive(1'b1, 16'h4003, 8'h19);
        check("R6 data strobe 4003", {fm_addr_stb, fm_data_stb}, 2'b01);
        loc_end();
        #1 check("R6 strobe one cycle", fm_data_stb, 0);
    endtask

    task automatic t_bank();
        logic [8:0] v = 9'h1A5;
        for (int i = 0; i < 9; i++) bank_write(v[i]);
        check("R2 model after nine writes", exp_bank, 9'h1A5);
        host_xfer("R2 full load", 1'b0, 16'hC123, 8'h00, 2, 8'hE7);
        bank_write(1'b0);
        bank_write(1'b1);
        host_xfer("R2 partial shift", 1'b0, 16'hFFFF, 8'h00, 0, 8'h11);
    endtask

    task automatic t_host();
        host_xfer("R8 write", 1'b1, 16'h8ABC, 8'hC3, 1, 8'h00);
        host_xfer("R7 long read", 1'b0, 16'h9001, 8'h00, 5, 8'h96);
        loc_drive(1'b1, 16'h4001, 8'h01);
        loc_end();
        host_xfer("R10 bank kept", 1'b1, 16'h8000, 8'h5E, 0, 8'h00);
    endtask

    task automatic t_unmapped();
        loc_drive(1'b0, 16'h1234, 8'h00);
        check("R9 unmapped read", loc_rdata, 8'hFF);
        loc_end();
        loc_drive(1'b0, 16'h6000, 8'h00);
        check("R9 bank address read", loc_rdata, 8'hFF);
        loc_end();
        loc_drive(1'b0, 16'h4004, 8'h00);
        check("R9 read past FM group", loc_rdata, 8'hFF);
        loc_end();
        loc_drive(1'b1, 16'h6001, 8'hFF);
        check("R9 unmapped write strobes", {fm_addr_stb, fm_data_stb, loc_wait}, 3'b000);
        loc_end();
        loc_drive(1'b1, 16'h2000, 8'hFF);
        check("R9 write no wait", loc_wait, 0);
        loc_end();
        #1 check("R9 no host request", host_req, 0);
        host_xfer("R9 bank unchanged", 1'b0, 16'hA000, 8'h00, 0, 8'h42);
    endtask

    initial begin
        t_reset();
        t_fm();
        t_bank();
        t_host();
        t_unmapped();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule